// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Registers

This block is a slice of the host register file in a byte-wide, legacy-style Ethernet controller. It keeps the interrupt status byte, the per-attempt collision count and the backup receive page pointer, all visible on register page 0. Completion and error strobes from the transmit, receive, remote DMA and tally-counter logic set the status bits. The host reads them and clears each one by writing a 1 to it. The interrupt line is raised while any event bit is pending.

The topmost status bit reports that the controller has been reset or woken. Only a start command clears it, and host writes cannot touch it. The collision count rises by one for each collision of the current transmit attempt and stops at its maximum. An excessive-collision abort or a new transmit command returns it to zero. The receive page pointer is loaded from the page-start value by the buffer logic, and it is brought out so that the receive pointers can be restored after an error. A write to the page pointer's offset lands in the transmit byte count high byte instead.

Top module: `eth_irq_regs`

## Requirements
- R1: After reset the status byte (offset 7h) reads 80h, the collision count (offset 5h) reads 00h, the page pointer (offset 6h) reads 4Dh, `irq_o` is 0 and `tbcr_hi_o` is 00h.
- R2: Status bit 7 is set by reset or by `wake_i` and cleared by `start_cmd_i`. If both strobes arrive in the same cycle, wake wins. Host writes do not change bit 7.
- R3: Status bits 6..0 mean remote DMA done (6), tally overflow (5), receive ring overwrite (4), transmit error (3), receive error (2), packet sent (1) and packet received (0). Each bit is set by its strobe and cleared by writing 1 to that bit at offset 7h. Writing 0 leaves the bit unchanged.
- R4: Bit 3 is set by an excessive-collision abort, a transmit oversize or a late collision. Bit 2 is set by a CRC error, an alignment error or a missed packet.
- R5: Bit 5 is set when any bit of `tally_msb_i` goes from 0 to 1. An input that stays at 1 does not set the bit again after it has been cleared.
- R6: When a set strobe and a write-1 clear reach the same status bit in one cycle, the bit ends up set.
- R7: At offset 5h, bits 7..4 read 0 and bits 3..0 hold the count. The count rises by 1 for each `col_event_i` and saturates at 15.
- R8: `tx_abort_i` or `txp_cmd_i` clears the collision count to 0, and this takes priority over a collision in the same cycle.
- R9: `pstart_ld_i` loads `pstart_i` into the page pointer, which reads at offset 6h and is driven on `cpr_o`. A host write to offset 6h updates `tbcr_hi_o` and leaves the page pointer unchanged.
- R10: `irq_o` is the OR of status bits 6..0. Reads have no side effect.
- R11: When `page_i` is not 0, host writes have no effect and reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_i | input | 2 | Register page selected by the command register |
| bus_addr_i | input | 4 | Host register offset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data (combinational) |
| start_cmd_i | input | 1 | Start command written to the command register |
| txp_cmd_i | input | 1 | Transmit-packet command bit set |
| wake_i | input | 1 | Wake-up event |
| rdma_done_i | input | 1 | Remote DMA finished |
| tally_msb_i | input | 3 | Most significant bit of each tally counter |
| rx_ovw_i | input | 1 | Receive ring storage exhausted |
| tx_abort_i | input | 1 | Transmit aborted on excessive collisions |
| tx_oversize_i | input | 1 | Transmit frame too long |
| tx_late_col_i | input | 1 | Late collision |
| rx_crc_err_i | input | 1 | Receive CRC error |
| rx_align_err_i | input | 1 | Receive frame alignment error |
| rx_missed_i | input | 1 | Missed receive packet |
| tx_ok_i | input | 1 | Packet sent without error |
| rx_ok_i | input | 1 | Packet received without error |
| col_event_i | input | 1 | One collision in the current attempt |
| pstart_ld_i | input | 1 | Load the page pointer from the page start |
| pstart_i | input | 8 | Page start value |
| cpr_o | output | 8 | Current receive page pointer |
| tbcr_hi_o | output | 8 | Transmit byte count, high byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a set strobe and a write-1 clear landing on the same status bit in one clock. The stimulus table contains a row that raises the received-packet strobe and writes 01h to offset 7h in the same cycle, and the row after it clears the bit alone. Edge detection of tally overflow is the other subtle case. The tally inputs are held as levels across several rows, so that a bit that is cleared while its input is still high must stay clear until another input rises.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_NCR = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_CPR = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_ISR = 4'h7;
  // status bit positions (host software decodes these)
  localparam int B_PRX = 0;
  localparam int B_PTX = 1;
  localparam int B_RXE = 2;
  localparam int B_TXE = 3;
  localparam int B_OVW = 4;
  localparam int B_CNT = 5;
  localparam int B_RDC = 6;
  localparam int B_RST = 7;
  localparam int EV_W  = 7;
endpackage

// File: rtl/eth_irq_events.sv
module eth_irq_events #(
  parameter int NUM_TALLY = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rdma_done_i,
  input  logic [NUM_TALLY-1:0]           tally_msb_i,
  input  logic                           rx_ovw_i,
  input  logic                           tx_abort_i,
  input  logic                           tx_oversize_i,
  input  logic                           tx_late_col_i,
  input  logic                           rx_crc_err_i,
  input  logic                           rx_align_err_i,
  input  logic                           rx_missed_i,
  input  logic                           tx_ok_i,
  input  logic                           rx_ok_i,
  output logic [eth_irq_pkg::EV_W-1:0]   set_o
);
  import eth_irq_pkg::*;

  logic [NUM_TALLY-1:0] tally_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tally_q <= '0;
    else         tally_q <= tally_msb_i;
  end

  always_comb begin
    set_o        = '0;
    set_o[B_PRX] = rx_ok_i;
    set_o[B_PTX] = tx_ok_i;
    set_o[B_RXE] = rx_crc_err_i | rx_align_err_i | rx_missed_i;
    set_o[B_TXE] = tx_abort_i | tx_oversize_i | tx_late_col_i;
    set_o[B_OVW] = rx_ovw_i;
    set_o[B_CNT] = |(tally_msb_i & ~tally_q);
    set_o[B_RDC] = rdma_done_i;
  end
endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [eth_irq_pkg::EV_W-1:0]  set_i,
  input  logic [eth_irq_pkg::EV_W-1:0]  clr_i,
  input  logic                          wake_i,
  input  logic                          start_i,
  output logic [7:0]                    isr_o
);
  import eth_irq_pkg::*;

  logic rst_bit_q;

  for (genvar b = 0; b < EV_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[b]) bit_q <= 1'b1;  // set beats clear
      else if (clr_i[b]) bit_q <= 1'b0;
    end
    assign isr_o[b] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rst_bit_q <= 1'b1;
    else if (wake_i)  rst_bit_q <= 1'b1;
    else if (start_i) rst_bit_q <= 1'b0;
  end

  assign isr_o[B_RST] = rst_bit_q;
endmodule

// File: rtl/eth_col_count.sv
module eth_col_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             col_i,
  input  logic             abort_i,
  input  logic             txp_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (abort_i || txp_i)           cnt_q <= '0;
    else if (col_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/eth_host_regs.sv
module eth_host_regs #(
  parameter int          CNT_W   = 4,
  parameter logic [7:0]  CPR_RST = 8'h4D
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  pg0_i,
  input  logic [eth_irq_pkg::ADDR_W-1:0]        addr_i,
  input  logic                                  wr_i,
  input  logic [eth_irq_pkg::DATA_W-1:0]        wdata_i,
  input  logic                                  pstart_ld_i,
  input  logic [7:0]                            pstart_i,
  input  logic [7:0]                            isr_i,
  input  logic [CNT_W-1:0]                      ncr_i,
  output logic [eth_irq_pkg::DATA_W-1:0]        rdata_o,
  output logic [eth_irq_pkg::EV_W-1:0]          clr_o,
  output logic [7:0]                            cpr_o,
  output logic [7:0]                            tbcr_hi_o
);
  import eth_irq_pkg::*;

  logic       wr_pg0;
  logic [7:0] cpr_q, tbcr_q;

  assign wr_pg0 = wr_i & pg0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cpr_q <= CPR_RST;
    else if (pstart_ld_i) cpr_q <= pstart_i;
  end

  // shared offset: writes reach the byte count, reads return the page pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           tbcr_q <= '0;
    else if (wr_pg0 && addr_i == OFS_CPR)  tbcr_q <= wdata_i;
  end

  assign clr_o = (wr_pg0 && addr_i == OFS_ISR) ? wdata_i[EV_W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (pg0_i) begin
      unique case (addr_i)
        OFS_NCR: rdata_o = DATA_W'(ncr_i);
        OFS_CPR: rdata_o = cpr_q;
        OFS_ISR: rdata_o = isr_i;
        default: rdata_o = '0;
      endcase
    end
  end

  assign cpr_o     = cpr_q;
  assign tbcr_hi_o = tbcr_q;
endmodule

// File: rtl/eth_irq_regs.sv
module eth_irq_regs #(
  parameter int         NUM_TALLY = 3,
  parameter int         CNT_W     = 4,
  parameter int         PAGE_W    = 2,
  parameter logic [7:0] CPR_RST   = 8'h4D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PAGE_W-1:0]    page_i,
  input  logic [3:0]           bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [7:0]           bus_wdata_i,
  output logic [7:0]           bus_rdata_o,
  input  logic                 start_cmd_i,
  input  logic                 txp_cmd_i,
  input  logic                 wake_i,
  input  logic                 rdma_done_i,
  input  logic [NUM_TALLY-1:0] tally_msb_i,
  input  logic                 rx_ovw_i,
  input  logic                 tx_abort_i,
  input  logic                 tx_oversize_i,
  input  logic                 tx_late_col_i,
  input  logic                 rx_crc_err_i,
  input  logic                 rx_align_err_i,
  input  logic                 rx_missed_i,
  input  logic                 tx_ok_i,
  input  logic                 rx_ok_i,
  input  logic                 col_event_i,
  input  logic                 pstart_ld_i,
  input  logic [7:0]           pstart_i,
  output logic [7:0]           cpr_o,
  output logic [7:0]           tbcr_hi_o,
  output logic                 irq_o
);
  import eth_irq_pkg::*;

  logic [EV_W-1:0]  ev_set, ev_clr;
  logic [7:0]       isr;
  logic [CNT_W-1:0] ncr;
  logic             pg0;

  assign pg0 = (page_i == '0);

  eth_irq_events #(.NUM_TALLY(NUM_TALLY)) u_events (
    .clk_i, .rst_ni, .rdma_done_i, .tally_msb_i, .rx_ovw_i,
    .tx_abort_i, .tx_oversize_i, .tx_late_col_i,
    .rx_crc_err_i, .rx_align_err_i, .rx_missed_i,
    .tx_ok_i, .rx_ok_i, .set_o(ev_set)
  );

  eth_irq_status u_status (
    .clk_i, .rst_ni, .set_i(ev_set), .clr_i(ev_clr),
    .wake_i, .start_i(start_cmd_i), .isr_o(isr)
  );

  eth_col_count #(.CNT_W(CNT_W)) u_col (
    .clk_i, .rst_ni, .col_i(col_event_i), .abort_i(tx_abort_i),
    .txp_i(txp_cmd_i), .cnt_o(ncr)
  );

  eth_host_regs #(.CNT_W(CNT_W), .CPR_RST(CPR_RST)) u_host (
    .clk_i, .rst_ni, .pg0_i(pg0), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .wdata_i(bus_wdata_i), .pstart_ld_i, .pstart_i, .isr_i(isr),
    .ncr_i(ncr), .rdata_o(bus_rdata_o), .clr_o(ev_clr),
    .cpr_o, .tbcr_hi_o
  );

  assign irq_o = |isr[EV_W-1:0];
endmodule

// File: rtl/eth_irq_regs_chk.sv
module eth_irq_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] isr,
  input logic [3:0] ncr,
  input logic [7:0] cpr,
  input logic [6:0] clr,
  input logic       rx_ok_i,
  input logic       tx_ok_i,
  input logic       start_cmd_i,
  input logic       wake_i,
  input logic       col_event_i,
  input logic       tx_abort_i,
  input logic       txp_cmd_i,
  input logic       pstart_ld_i,
  input logic [7:0] pstart_i
);
  logic ncr_clr;
  assign ncr_clr = tx_abort_i | txp_cmd_i;

  p_rst_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr[7] && !start_cmd_i) |=> isr[7]);
  p_rst_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_cmd_i && !wake_i) |=> !isr[7]);
  p_w1c_ptx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr[1] && !tx_ok_i) |=> !isr[1]);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_i |=> isr[0]);
  p_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_event_i && !ncr_clr && ncr != 4'hF) |=> ncr == $past(ncr) + 4'd1);
  p_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ncr == 4'hF && !ncr_clr) |=> ncr == 4'hF);
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ncr_clr |=> ncr == 4'h0);
  p_cpr_ld_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstart_ld_i |=> cpr == $past(pstart_i));
endmodule

bind eth_irq_regs eth_irq_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .isr(isr), .ncr(ncr), .cpr(cpr_o),
  .clr(ev_clr), .rx_ok_i(rx_ok_i), .tx_ok_i(tx_ok_i),
  .start_cmd_i(start_cmd_i), .wake_i(wake_i), .col_event_i(col_event_i),
  .tx_abort_i(tx_abort_i), .txp_cmd_i(txp_cmd_i),
  .pstart_ld_i(pstart_ld_i), .pstart_i(pstart_i)
);

// File: tb/eth_irq_regs_tb_top.sv
module eth_irq_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] page = '0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic start = 0, txp = 0, wake = 0, rdma = 0, ovw = 0, abrt = 0, ovs = 0, late = 0;
  logic crc = 0, aln = 0, mis = 0, txok = 0, rxok = 0, col = 0, pld = 0;
  logic [2:0] tally = '0;
  logic [7:0] pstart = '0;
  logic [7:0] cpr, tbcr;
  logic       irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eth_irq_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .page_i(page), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .start_cmd_i(start), .txp_cmd_i(txp), .wake_i(wake), .rdma_done_i(rdma),
    .tally_msb_i(tally), .rx_ovw_i(ovw), .tx_abort_i(abrt),
    .tx_oversize_i(ovs), .tx_late_col_i(late), .rx_crc_err_i(crc),
    .rx_align_err_i(aln), .rx_missed_i(mis), .tx_ok_i(txok), .rx_ok_i(rxok),
    .col_event_i(col), .pstart_ld_i(pld), .pstart_i(pstart),
    .cpr_o(cpr), .tbcr_hi_o(tbcr), .irq_o(irq)
  );

  // {req[3:0], ev[9:0], tally[2:0], wr, wdata[7:0], exp_isr[7:0]}
  // ev: 0 rx_ok 1 tx_ok 2 crc 3 align 4 missed 5 abort 6 oversize 7 late 8 ovw 9 rdma
  localparam int NV = 30;
  localparam logic [33:0] VEC [NV] = '{
    {4'd3, 10'h001, 3'b000, 1'b0, 8'h00, 8'h81},
    {4'd3, 10'h002, 3'b000, 1'b0, 8'h00, 8'h83},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h01, 8'h82},
    {4'd2, 10'h000, 3'b000, 1'b1, 8'h80, 8'h82},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h00, 8'h82},
    {4'd4, 10'h004, 3'b000, 1'b0, 8'h00, 8'h86},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h06, 8'h80},
    {4'd4, 10'h008, 3'b000, 1'b0, 8'h00, 8'h84},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h04, 8'h80},
    {4'd4, 10'h010, 3'b000, 1'b0, 8'h00, 8'h84},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h04, 8'h80},
    {4'd4, 10'h020, 3'b000, 1'b0, 8'h00, 8'h88},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h08, 8'h80},
    {4'd4, 10'h040, 3'b000, 1'b0, 8'h00, 8'h88},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h08, 8'h80},
    {4'd4, 10'h080, 3'b000, 1'b0, 8'h00, 8'h88},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h08, 8'h80},
    {4'd3, 10'h100, 3'b000, 1'b0, 8'h00, 8'h90},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h10, 8'h80},
    {4'd3, 10'h200, 3'b000, 1'b0, 8'h00, 8'hC0},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h40, 8'h80},
    {4'd5, 10'h000, 3'b001, 1'b0, 8'h00, 8'hA0},
    {4'd5, 10'h000, 3'b001, 1'b1, 8'h20, 8'h80},
    {4'd5, 10'h000, 3'b001, 1'b0, 8'h00, 8'h80},
    {4'd5, 10'h000, 3'b011, 1'b0, 8'h00, 8'hA0},
    {4'd5, 10'h000, 3'b011, 1'b1, 8'h20, 8'h80},
    {4'd5, 10'h000, 3'b000, 1'b0, 8'h00, 8'h80},
    {4'd6, 10'h001, 3'b000, 1'b1, 8'h01, 8'h81},
    {4'd3, 10'h000, 3'b000, 1'b1, 8'h01, 8'h80},
    {4'd6, 10'h202, 3'b000, 1'b1, 8'h42, 8'hC2}
  };

  function automatic string rtag(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] pg, input logic [3:0] a, output logic [7:0] d);
    page = pg; addr = a; #1; d = rdata; page = '0;
  endtask

  task automatic apply(input logic [9:0] ev, input logic w, input logic [7:0] wd, input logic [3:0] a);
    @(negedge clk);
    {rdma, ovw, late, ovs, abrt, mis, aln, crc, txok, rxok} = ev;
    wr = w; wdata = wd; addr = a;
    @(negedge clk);
    {rdma, ovw, late, ovs, abrt, mis, aln, crc, txok, rxok} = '0;
    wr = 0; wdata = '0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 4'h7, d); chk("R1 isr", d, 8'h80);
    rd(2'd0, 4'h5, d); chk("R1 ncr", d, 8'h00);
    rd(2'd0, 4'h6, d); chk("R1 cpr", d, 8'h4D);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tbcr", tbcr, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      tally = v[19:17];
      apply(v[29:20], v[16], v[15:8], 4'h7);
      rd(2'd0, 4'h7, d);
      chk($sformatf("%s vec %0d isr", rtag(int'(v[33:30])), i), d, v[7:0]);
      chk($sformatf("R10 vec %0d irq", i), {7'd0, irq}, {7'd0, |v[6:0]});
    end
    apply(10'h0, 1'b1, 8'h42, 4'h7);
    rd(2'd0, 4'h7, d); chk("R3 final clear", d, 8'h80);

    // R2 start clears, writes ignored, wake sets, wake beats start
    pulse(start);
    rd(2'd0, 4'h7, d); chk("R2 start clears", d, 8'h00);
    apply(10'h0, 1'b1, 8'h80, 4'h7);
    rd(2'd0, 4'h7, d); chk("R2 write 1 ignored", d, 8'h00);
    pulse(wake);
    rd(2'd0, 4'h7, d); chk("R2 wake sets", d, 8'h80);
    chk("R10 irq ignores bit 7", {7'd0, irq}, 8'h00);
    @(negedge clk); start = 1; wake = 1; @(negedge clk); start = 0; wake = 0;
    rd(2'd0, 4'h7, d); chk("R2 wake beats start", d, 8'h80);

    // R7 counting and saturation
    repeat (3) pulse(col);
    rd(2'd0, 4'h5, d); chk("R7 count 3", d, 8'h03);
    repeat (14) pulse(col);
    rd(2'd0, 4'h5, d); chk("R7 saturate", d, 8'h0F);

    // R8 clears
    apply(10'h020, 1'b0, 8'h00, 4'h7);
    rd(2'd0, 4'h5, d); chk("R8 abort clears", d, 8'h00);
    apply(10'h0, 1'b1, 8'h08, 4'h7);
    repeat (2) pulse(col);
    rd(2'd0, 4'h5, d); chk("R7 count 2", d, 8'h02);
    pulse(txp);
    rd(2'd0, 4'h5, d); chk("R8 txp clears", d, 8'h00);
    pulse(col);
    @(negedge clk); col = 1; txp = 1; @(negedge clk); col = 0; txp = 0;
    rd(2'd0, 4'h5, d); chk("R8 clear beats collision", d, 8'h00);

    // R9 page pointer and shared offset
    pstart = 8'h46; pulse(pld);
    rd(2'd0, 4'h6, d); chk("R9 load", d, 8'h46);
    chk("R9 cpr_o", cpr, 8'h46);
    apply(10'h0, 1'b1, 8'h12, 4'h6);
    chk("R9 tbcr write", tbcr, 8'h12);
    rd(2'd0, 4'h6, d); chk("R9 cpr unchanged", d, 8'h46);

    // R10 reads without side effect
    apply(10'h001, 1'b0, 8'h00, 4'h7);
    rd(2'd0, 4'h7, d); rd(2'd0, 4'h7, d);
    @(negedge clk);
    rd(2'd0, 4'h7, d); chk("R10 read keeps status", d, 8'h81);
    chk("R10 irq set", {7'd0, irq}, 8'h01);

    // R11 other page
    @(negedge clk); page = 2'd1; addr = 4'h7; wr = 1; wdata = 8'h01;
    @(negedge clk); wr = 0; wdata = 0;
    rd(2'd1, 4'h7, d); chk("R11 read other page", d, 8'h00);
    page = 2'd1; addr = 4'h6; wr = 1; wdata = 8'h77;
    @(negedge clk); wr = 0; page = '0;
    chk("R11 tbcr untouched", tbcr, 8'h12);
    rd(2'd0, 4'h7, d); chk("R11 status untouched", d, 8'h81);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule